// File: doc/BRIEF.md
# Serial Radix-4 Booth Multiply-Accumulator

This block forms sums of products of a coefficient word and a data word, two multiplier bits per clock. The coefficient is captured into a parallel register. The data word goes into a shift register that hands its bits out two at a time, with one bit of overlap. Each overlapping triple picks a partial product of 0, ±A or ±2A. That partial product is added into a high accumulator that is two bits wider than the operands. The sum then shifts right by two places. The two bits that fall off the bottom are final result bits. They leave on a serial output and are kept in a low register, so the block holds the whole product at full precision.

A start strobe begins an operation. One control chooses between clearing the running total and adding to it. A second control chooses between taking a fresh coefficient and reusing the one already held. After the last Booth step, a fold cycle adds the high part that was kept from the previous total. An output stage then rounds the full-precision total half-up at a chosen bit position, saturates it to the operand width and registers it, together with a one-cycle done pulse. The memories and the sequencer that would drive the block sit outside it.

Top module: `serial_booth_mac`

## Requirements
- R1: With acc_clear=1, after a start the result equals the exact signed product coef_in×data_in (two's complement, WD bits each) divided by 2^OUT_SHIFT, rounded and saturated as given in R5 and R6. Defaults are WD=16 and OUT_SHIFT=15. The result register changes only in the cycle in which done is high.
- R2: A start sampled at clock edge n gives done high in the cycle that follows edge n+WD/2+2. busy is high from edge n until edge n+WD/2+2.
- R3: With acc_clear=0 the new product is added to the previous total at full precision, including the bits below the output LSB.
- R4: With coef_hold=1 the coefficient captured by the previous operation is used again and coef_in is ignored.
- R5: A rounded total above 2^(WD-1)-1 gives 2^(WD-1)-1. A rounded total below -2^(WD-1) gives -2^(WD-1).
- R6: Rounding is half-up. The output is floor((total + 2^(OUT_SHIFT-1)) / 2^OUT_SHIFT), so +0.5 goes to 1, -0.5 goes to 0 and -1.5 goes to -1.
- R7: done is high for exactly one cycle per accepted start.
- R8: lsb_vld is high for WD/2 cycles while busy. In the i-th of these cycles (counting from 0), lsb_pair carries bits 2i+1:2i of the new total.
- R9: A start raised while busy is ignored. It changes neither the timing nor the result.
- R10: During and right after reset, busy, done and lsb_vld are 0 and the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| acc_clear | input | 1 | 1: start from zero; 0: add to previous total |
| coef_hold | input | 1 | 1: reuse held coefficient; 0: capture coef_in |
| coef_in | input | WD | Coefficient operand (signed) |
| data_in | input | WD | Data operand, Booth-recoded (signed) |
| busy | output | 1 | Operation in progress |
| lsb_vld | output | 1 | lsb_pair carries result bits |
| lsb_pair | output | 2 | Two low result bits per Booth step |
| done | output | 1 | One-cycle pulse, result updated |
| result | output | WD | Rounded, saturated total |

## Verification
Directed vectors target the Booth recoder's extreme digits: most-negative operands on both sides, all-ones and alternating multiplier patterns. These show whether the sign handling and the ±2A choice are correct. Tie values just above and below half an output LSB check the round direction for both signs. Products at full scale, single and accumulated, push the output into saturation in both directions. A chain that accumulates a product just under half an LSB and then a single-unit product shows whether the low-order bits survive between operations. Random chains mix clearing, accumulation and coefficient reuse. They also include stray starts during an operation, and each total is checked both through the rounded result and through the serial low bits.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [2:0] {
      BD_ZERO,
      BD_POS1,
      BD_POS2,
      BD_NEG1,
      BD_NEG2
   } booth_dig_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_STEP,
      ST_FOLD,
      ST_EMIT
   } mac_state_e;

   // triple = {b[2i+1], b[2i], b[2i-1]}
   function automatic booth_dig_e booth_recode(input logic [2:0] triple);
      booth_dig_e d;
      case (triple)
         3'b001, 3'b010: d = BD_POS1;
         3'b011:         d = BD_POS2;
         3'b100:         d = BD_NEG2;
         3'b101, 3'b110: d = BD_NEG1;
         default:        d = BD_ZERO;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/booth_select.sv
module booth_select #(
   parameter int WD = 16,
   parameter int SW = WD + 3
) (
   input  logic [2:0]           triple,
   input  logic signed [WD-1:0] mcand,
   output logic signed [SW-1:0] pp
);
   import mac_pkg::*;

   booth_dig_e             dig;
   logic signed [SW-1:0]   a_ext;
   logic signed [SW-1:0]   a_dbl;

   always_comb begin
      dig   = booth_recode(triple);
      a_ext = SW'(mcand);
      a_dbl = a_ext <<< 1;
      case (dig)
         BD_POS1: pp = a_ext;
         BD_POS2: pp = a_dbl;
         BD_NEG1: pp = -a_ext;
         BD_NEG2: pp = -a_dbl;
         default: pp = '0;
      endcase
   end

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl #(
   parameter int STEPS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ld,
   output logic step_en,
   output logic fold_en,
   output logic emit_en,
   output logic busy,
   output logic done
);
   import mac_pkg::*;

   localparam int CW = $clog2(STEPS + 1);

   mac_state_e      st_q;
   logic [CW-1:0]   cnt_q;

   assign ld      = (st_q == ST_IDLE) && start;
   assign step_en = (st_q == ST_STEP);
   assign fold_en = (st_q == ST_FOLD);
   assign emit_en = (st_q == ST_EMIT);
   assign busy    = (st_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            ST_IDLE: if (start) begin
               st_q  <= ST_STEP;
               cnt_q <= '0;
            end
            ST_STEP: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CW'(STEPS - 1)) st_q <= ST_FOLD;
            end
            ST_FOLD: st_q <= ST_EMIT;
            default: begin
               st_q <= ST_IDLE;
               done <= 1'b1;
            end
         endcase
      end
   end

   // R7: done lasts a single cycle
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: an idle start is taken at once
   a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && step_en));

   // R2: the step counter stays within the Booth digit count
   a_r2_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |-> (cnt_q < CW'(STEPS)));

   // R7: done only follows the emit cycle
   a_r7_done_after_emit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(emit_en));

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
   parameter int WD = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld,
   input  logic                    step_en,
   input  logic                    fold_en,
   input  logic                    acc_clear,
   input  logic                    coef_hold,
   input  logic [WD-1:0]           coef_in,
   input  logic [WD-1:0]           data_in,
   output logic signed [2*WD+1:0]  acc_full,
   output logic [1:0]              lsb_pair
);
   localparam int AW = WD + 2;
   localparam int SW = WD + 3;

   logic signed [WD-1:0]  coef_q;
   logic [WD-1:0]         mplr_q;
   logic                  prev_q;
   logic signed [AW-1:0]  hi_q;
   logic signed [AW-1:0]  hold_q;
   logic [WD-1:0]         lo_q;

   logic signed [SW-1:0]  pp;
   logic signed [SW-1:0]  hi_sum;
   logic signed [SW-1:0]  hi_ext;
   logic [SW-1:0]         lo_feed;

   booth_select #(.WD(WD), .SW(SW)) u_sel (
      .triple ({mplr_q[1:0], prev_q}),
      .mcand  (coef_q),
      .pp     (pp)
   );

   always_comb begin
      hi_ext  = SW'(hi_q);
      lo_feed = {{(SW-2){1'b0}}, lo_q[1:0]};
      hi_sum  = hi_ext + pp + $signed(lo_feed);
   end

   assign lsb_pair = hi_sum[1:0];
   assign acc_full = {hi_q, lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coef_q <= '0;
         mplr_q <= '0;
         prev_q <= 1'b0;
         hi_q   <= '0;
         hold_q <= '0;
         lo_q   <= '0;
      end else if (ld) begin
         if (!coef_hold) coef_q <= $signed(coef_in);
         mplr_q <= data_in;
         prev_q <= 1'b0;
         hi_q   <= '0;
         if (acc_clear) begin
            hold_q <= '0;
            lo_q   <= '0;
         end else begin
            hold_q <= hi_q;
         end
      end else if (step_en) begin
         mplr_q <= {{2{mplr_q[WD-1]}}, mplr_q[WD-1:2]};
         prev_q <= mplr_q[1];
         lo_q   <= {hi_sum[1:0], lo_q[WD-1:2]};
         hi_q   <= {hi_sum[SW-1], hi_sum[SW-1:2]};
      end else if (fold_en) begin
         hi_q <= hi_q + hold_q;
      end
   end

   // R4: the coefficient stays put while an operation runs
   a_r4_coef_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && $past(step_en)) |-> $stable(coef_q));

   // R3: the kept high part does not move outside a load
   a_r3_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ld) |-> $stable(hold_q));

endmodule

// File: rtl/mac_outstage.sv
module mac_outstage #(
   parameter int WD            = 16,
   parameter int OUT_SHIFT     = 15,
   parameter bit ROUND_HALF_UP = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    emit_en,
   input  logic signed [2*WD+1:0]  acc_full,
   output logic [WD-1:0]           result
);
   localparam int TW = 2 * WD + 2;
   localparam logic signed [TW:0] MAXV = {{(TW-WD+2){1'b0}}, {(WD-1){1'b1}}};
   localparam logic signed [TW:0] MINV = {{(TW-WD+2){1'b1}}, {(WD-1){1'b0}}};

   logic signed [TW:0] ext;
   logic signed [TW:0] biased;
   logic signed [TW:0] scaled;
   logic [WD-1:0]      sat_val;

   assign ext = {acc_full[TW-1], acc_full};

   generate
      if (ROUND_HALF_UP) begin : g_round
         localparam logic signed [TW:0] HALF = (TW+1)'(1) <<< (OUT_SHIFT - 1);
         assign biased = ext + HALF;
      end else begin : g_trunc
         assign biased = ext;
      end
   endgenerate

   always_comb begin
      scaled = biased >>> OUT_SHIFT;
      if (scaled > MAXV)      sat_val = MAXV[WD-1:0];
      else if (scaled < MINV) sat_val = MINV[WD-1:0];
      else                    sat_val = scaled[WD-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       result <= '0;
      else if (emit_en) result <= sat_val;
   end

   // R1: the result only moves on an emit cycle
   a_r1_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !emit_en |=> $stable(result));

endmodule

// File: rtl/serial_booth_mac.sv
module serial_booth_mac #(
   parameter int WD            = 16,
   parameter int OUT_SHIFT     = WD - 1,
   parameter bit ROUND_HALF_UP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          acc_clear,
   input  logic          coef_hold,
   input  logic [WD-1:0] coef_in,
   input  logic [WD-1:0] data_in,
   output logic          busy,
   output logic          lsb_vld,
   output logic [1:0]    lsb_pair,
   output logic          done,
   output logic [WD-1:0] result
);
   localparam int STEPS = WD / 2;

   generate
      if ((WD % 2) != 0 || WD < 4) begin : g_bad_wd
         $error("serial_booth_mac: WD must be even and at least 4");
      end
      if (OUT_SHIFT < 1 || OUT_SHIFT > 2 * WD) begin : g_bad_shift
         $error("serial_booth_mac: OUT_SHIFT out of range");
      end
   endgenerate

   logic                   ld, step_en, fold_en, emit_en;
   logic signed [2*WD+1:0] acc_full;

   mac_ctrl #(.STEPS(STEPS)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .ld      (ld),
      .step_en (step_en),
      .fold_en (fold_en),
      .emit_en (emit_en),
      .busy    (busy),
      .done    (done)
   );

   mac_datapath #(.WD(WD)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (ld),
      .step_en   (step_en),
      .fold_en   (fold_en),
      .acc_clear (acc_clear),
      .coef_hold (coef_hold),
      .coef_in   (coef_in),
      .data_in   (data_in),
      .acc_full  (acc_full),
      .lsb_pair  (lsb_pair)
   );

   mac_outstage #(.WD(WD), .OUT_SHIFT(OUT_SHIFT), .ROUND_HALF_UP(ROUND_HALF_UP)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .emit_en  (emit_en),
      .acc_full (acc_full),
      .result   (result)
   );

   assign lsb_vld = step_en;

   // R8: serial bits only appear during an operation
   a_r8_lsb_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      lsb_vld |-> busy);

   // R9: a start while busy does not restart the steps
   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !lsb_vld) |=> !$rose(lsb_vld) || !$past(busy));

endmodule

// File: tb/serial_booth_mac_tb.sv
module serial_booth_mac_tb;
   localparam int WD = 16;
   localparam int SH = 15;
   localparam int K  = WD / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, acc_clear = 1'b1, coef_hold = 1'b0;
   logic [WD-1:0] coef_in = '0, data_in = '0;
   logic busy, lsb_vld, done;
   logic [1:0] lsb_pair;
   logic [WD-1:0] result;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;
   longint tot = 0;
   logic signed [WD-1:0] coef_m = '0;
   int chain = 0;

   always #10 clk = ~clk;

   serial_booth_mac #(.WD(WD), .OUT_SHIFT(SH), .ROUND_HALF_UP(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .acc_clear(acc_clear),
      .coef_hold(coef_hold), .coef_in(coef_in), .data_in(data_in),
      .busy(busy), .lsb_vld(lsb_vld), .lsb_pair(lsb_pair),
      .done(done), .result(result)
   );

   function automatic longint exp_res(input longint t);
      longint r;
      r = (t + (64'sd1 <<< (SH - 1))) >>> SH;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic clr, input logic hold,
                         input logic signed [WD-1:0] a, input logic signed [WD-1:0] b,
                         input bit poke, input string tag);
      logic signed [WD-1:0] a_eff;
      logic [WD-1:0] lsb_acc;
      int cnt;
      int vld_n;
      a_eff = hold ? coef_m : a;
      coef_m = a_eff;
      if (clr) tot = 0;
      tot = tot + longint'(a_eff) * longint'(b);
      lsb_acc = '0;
      vld_n = 0;
      cnt = 0;
      @(negedge clk);
      start = 1'b1; acc_clear = clr; coef_hold = hold; coef_in = a; data_in = b;
      @(posedge clk);
      forever begin
         @(negedge clk);
         cnt++;
         if (cnt == 1) begin
            start = 1'b0;
            coef_in = WD'($urandom); data_in = WD'($urandom);
            acc_clear = 1'($urandom); coef_hold = 1'($urandom);
         end
         if (poke && cnt == 3) start = 1'b1;
         if (poke && cnt == 4) start = 1'b0;
         if (lsb_vld) begin
            if (cnt - 1 < K) lsb_acc[2*(cnt-1) +: 2] = lsb_pair;
            vld_n++;
         end
         if (done || cnt > 40) break;
      end
      chk({tag, " result"}, longint'($signed(result)), exp_res(tot));
      chk("R2 latency", cnt, K + 3);
      chk("R8 serial low bits", longint'(lsb_acc), longint'(tot[WD-1:0]));
      chk("R8 serial cycles", vld_n, K);
      chk("R2 idle after done", busy, 0);
      @(negedge clk);
      chk("R7 done one cycle", done, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int seed_sink;
      seed_sink = $urandom(32'd1357);
      repeat (3) @(negedge clk);
      chk("R10 busy in reset", busy, 0);
      chk("R10 done in reset", done, 0);
      chk("R10 lsb_vld in reset", lsb_vld, 0);
      chk("R10 result in reset", result, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 idle after reset", busy, 0);

      run_op(1, 0, 16'sd1000, 16'sd2000, 0, "R1 small");
      run_op(1, 0, -16'sd12345, 16'sd23456, 0, "R1 mixed sign");
      run_op(1, 0, 16'sh5555, 16'shAAAA, 0, "R1 alternating");
      run_op(1, 0, 16'sd3, -16'sd1, 0, "R1 all-ones multiplier");
      run_op(1, 0, 16'sh7FFF, 16'sh7FFF, 0, "R1 max positive");
      run_op(1, 0, -16'sd32768, -16'sd32768, 0, "R5 positive saturation");
      run_op(1, 0, -16'sd32768, 16'sd32767, 0, "R5 near negative");
      run_op(0, 0, -16'sd32768, 16'sd32767, 0, "R5 negative saturation");
      run_op(1, 0, 16'sd1, 16'sd16384, 0, "R6 plus half");
      run_op(1, 0, -16'sd1, 16'sd16384, 0, "R6 minus half");
      run_op(1, 0, -16'sd3, 16'sd16384, 0, "R6 minus one and half");
      run_op(1, 0, 16'sd1, 16'sd16383, 0, "R3 below half");
      run_op(0, 0, 16'sd1, 16'sd1, 0, "R3 low bits kept");
      run_op(1, 0, 16'sd7, 16'sd9000, 0, "R4 capture");
      run_op(0, 1, 16'sd12345, 16'sd11000, 0, "R4 coefficient reuse");
      run_op(1, 0, 16'sd20000, -16'sd15000, 1, "R9 start while busy");
      chain = 0;

      for (int i = 0; i < 300; i++) begin
         logic clr;
         logic hold;
         clr = ($urandom_range(2) == 0) || (chain >= 3);
         hold = ($urandom_range(3) == 0);
         chain = clr ? 0 : chain + 1;
         run_op(clr, hold, WD'($urandom), WD'($urandom), ($urandom_range(4) == 0),
                "R1 random");
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule